// File: doc/BRIEF.md
# Interlocked Four-Stage Add Pipeline

This block is a very small processor core that runs one kind of instruction: a two-byte add between two registers. The instruction passes through four stages: fetch, decode, execute and writeback. Pipeline registers separate the stages. The core holds a 16 x 64-bit register file, a byte-addressed program counter and a small instruction ROM. The surrounding logic fills the ROM and the register file through load ports while the core is held in reset.

A read-after-write hazard occurs when an instruction in decode wants a register that an older add in execute or writeback has not yet written. The core has no forwarding paths. Instead it holds the program counter and the fetch/decode register, and it sends a do-nothing bubble (destination code 0xF) into execute. It keeps doing this until the producer has written back.

Each register-file write is shown on a debug port in the cycle the write takes place. That port is the only way to see results.

Top module: `add_pipe4`

## Requirements
- R1: Each ROM entry is a 16-bit instruction word at byte address 2*index. Word bits [15:12] are the source register rA and bits [11:8] are rB; bits [7:0] are ignored. When fetch is not stalled, the PC advances by 2 each cycle.
- R2: An instruction writes R[rA] + R[rB] (modulo 2^64) into R[rB].
- R3: Destination code 0xF names no register. Writeback with that destination leaves the register file unchanged and does not raise dbg_we.
- R4: Decode stalls while its rA or rB equals the destination of the instruction in execute or in writeback. A dependent instruction right behind its producer gets exactly two bubbles. With one instruction between them it gets exactly one.
- R5: During a stall the PC and the fetch/decode register keep their values and a bubble (destination 0xF) enters execute. No instruction is lost, and program order is kept.
- R6: Instructions with no hazard retire one per cycle. After reset is released, the first instruction's writeback appears in cycle 3, where cycle 0 is the first cycle out of reset.
- R7: Synchronous reset sets the PC to 0 and puts bubbles in all pipeline registers, so dbg_we stays low. Reset leaves the register file contents unchanged.
- R8: dbg_we is high exactly in each cycle in which writeback updates a register. In that cycle dbg_idx gives the register number and dbg_data gives the value written.
- R9: Destination code 0xF in execute or writeback never causes a stall, even when decode reads register 15.
- R10: rf_ld_en writes rf_ld_data into register rf_ld_idx at the clock edge. rom_ld_en writes rom_ld_data into ROM entry rom_ld_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_ld_en | input | 1 | Write strobe for an instruction ROM entry |
| rom_ld_addr | input | $clog2(ROM_DEPTH) | ROM entry index |
| rom_ld_data | input | 16 | Instruction word |
| rf_ld_en | input | 1 | Preload strobe for the register file |
| rf_ld_idx | input | 4 | Register number to preload |
| rf_ld_data | input | XLEN | Preload value |
| dbg_we | output | 1 | Writeback updates a register this cycle |
| dbg_idx | output | 4 | Register being written |
| dbg_data | output | XLEN | Value being written |

## Verification
Errors inside the core show up only on the debug port. A missing stall shows up as a wrong dbg_data value two to three cycles after the dependent instruction is fetched. An extra stall, or a lost instruction, moves every later writeback to a different cycle. Because of this, the bench checks each cycle against a table of expected cycle numbers, register numbers and values. A corrupted register file, or one cleared by reset, appears as a wrong sum at a later write to that register.

// File: rtl/add_pipe4.sv
`timescale 1ns/1ps
module add_pipe4 #(
  parameter int XLEN      = 64,
  parameter int ROM_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rom_ld_en,
  input  logic [$clog2(ROM_DEPTH)-1:0] rom_ld_addr,
  input  logic [15:0]                  rom_ld_data,
  input  logic                         rf_ld_en,
  input  logic [3:0]                   rf_ld_idx,
  input  logic [XLEN-1:0]              rf_ld_data,
  output logic                         dbg_we,
  output logic [3:0]                   dbg_idx,
  output logic [XLEN-1:0]              dbg_data
);
  localparam int RAW = $clog2(ROM_DEPTH);
  localparam int PCW = RAW + 1;
  localparam logic [3:0] NOREG = 4'hF;

  logic [15:0]     rom [ROM_DEPTH];
  logic [XLEN-1:0] rf  [16];

  logic [PCW-1:0]  pc;
  logic [3:0]      fd_ra, fd_rb;
  logic [XLEN-1:0] de_va, de_vb;
  logic [3:0]      de_dst;
  logic [XLEN-1:0] ew_val;
  logic [3:0]      ew_dst;

  logic [15:0] f_word;
  logic        hz_ex, hz_wb, stall;

  assign f_word = rom[pc[PCW-1:1]];

  assign hz_ex = (de_dst != NOREG) && (de_dst == fd_ra || de_dst == fd_rb);
  assign hz_wb = (ew_dst != NOREG) && (ew_dst == fd_ra || ew_dst == fd_rb);
  assign stall = hz_ex || hz_wb;

  always_ff @(posedge clk) begin
    if (rom_ld_en) rom[rom_ld_addr] <= rom_ld_data;
  end

  always_ff @(posedge clk) begin
    if (rf_ld_en)            rf[rf_ld_idx] <= rf_ld_data;
    else if (ew_dst != NOREG) rf[ew_dst]   <= ew_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      fd_ra <= NOREG;
      fd_rb <= NOREG;
    end else if (!stall) begin
      pc    <= pc + PCW'(2);
      fd_ra <= f_word[15:12];
      fd_rb <= f_word[11:8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stall) begin
      de_va  <= '0;
      de_vb  <= '0;
      de_dst <= NOREG;
    end else begin
      de_va  <= rf[fd_ra];
      de_vb  <= rf[fd_rb];
      de_dst <= fd_rb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ew_val <= '0;
      ew_dst <= NOREG;
    end else begin
      ew_val <= de_va + de_vb;
      ew_dst <= de_dst;
    end
  end

  assign dbg_we   = (ew_dst != NOREG);
  assign dbg_idx  = ew_dst;
  assign dbg_data = ew_val;
endmodule

// File: rtl/add_pipe4_chk.sv
`timescale 1ns/1ps
module add_pipe4_chk #(
  parameter int PCW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] pc,
  input logic           stall,
  input logic [3:0]     fd_ra,
  input logic [3:0]     fd_rb,
  input logic [3:0]     de_dst,
  input logic           dbg_we,
  input logic [3:0]     dbg_idx
);
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc == $past(pc) + PCW'(2)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc) && $stable(fd_ra) && $stable(fd_rb)); // R5

  AST_BUBBLE_IN: assert property (@(posedge clk) disable iff (rst)
    stall |=> de_dst == 4'hF); // R5

  AST_NO_WRITE_F: assert property (@(posedge clk) disable iff (rst)
    dbg_we |-> dbg_idx != 4'hF); // R3

  AST_STALL_MAX2: assert property (@(posedge clk) disable iff (rst)
    stall && $past(stall) |=> !stall); // R4

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> pc == '0 && de_dst == 4'hF && fd_ra == 4'hF); // R7
endmodule

bind add_pipe4 add_pipe4_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .stall(stall), .fd_ra(fd_ra),
  .fd_rb(fd_rb), .de_dst(de_dst), .dbg_we(dbg_we), .dbg_idx(dbg_idx));

// File: tb/sim_add_pipe4.sv
`timescale 1ns/1ps
module sim_add_pipe4;
  localparam int XLEN = 64;
  localparam int ROM_DEPTH = 32;
  localparam int RAW = $clog2(ROM_DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rom_ld_en = 1'b0;
  logic [RAW-1:0] rom_ld_addr = '0;
  logic [15:0] rom_ld_data = '0;
  logic rf_ld_en = 1'b0;
  logic [3:0] rf_ld_idx = '0;
  logic [XLEN-1:0] rf_ld_data = '0;
  logic dbg_we;
  logic [3:0] dbg_idx;
  logic [XLEN-1:0] dbg_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  add_pipe4 #(.XLEN(XLEN), .ROM_DEPTH(ROM_DEPTH)) u0 (.*);

  localparam int NPROG = 12;
  localparam logic [3:0] P_RA [NPROG] = '{4'd8, 4'd9, 4'd10, 4'd12, 4'd1, 4'd3,
                                          4'd13, 4'd5, 4'd15, 4'd6, 4'd7, 4'd6};
  localparam logic [3:0] P_RB [NPROG] = '{4'd9, 4'd8, 4'd11, 4'd13, 4'd2, 4'd4,
                                          4'd2, 4'd15, 4'd6, 4'd6, 4'd9, 4'd1};

  // expected writebacks: cycle after reset release, register, value
  localparam int NEXP = 11;
  localparam int  E_CYC [NEXP] = '{3, 6, 7, 8, 9, 10, 12, 14, 17, 18, 20};
  localparam int  E_REG [NEXP] = '{9, 8, 11, 13, 2, 4, 2, 6, 6, 9, 1};
  localparam longint E_VAL [NEXP] = '{1700, 2500, 2100, 2500, 300, 700,
                                      2800, 2100, 4200, 2400, 4300};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    bit exp_we;
    @(negedge clk);
    for (int n = 0; n < 16; n++) begin
      rf_ld_en = 1'b1; rf_ld_idx = 4'(n); rf_ld_data = XLEN'(n * 100);
      @(negedge clk);
    end
    rf_ld_en = 1'b0;
    for (int a = 0; a < ROM_DEPTH; a++) begin
      rom_ld_en = 1'b1; rom_ld_addr = RAW'(a);
      rom_ld_data = (a < NPROG) ? {P_RA[a], P_RB[a], 8'h60} : 16'hFF00; // R1 fields
      @(negedge clk);
    end
    rom_ld_en = 1'b0;
    // R7 reset state
    chk(dbg_we == 1'b0, "R7 reset dbg_we", longint'(dbg_we), 0);
    chk(dbg_idx == 4'hF, "R7 reset dbg_idx", longint'(dbg_idx), 15);

    rst = 1'b0;
    // table walk: R1 R2 R3 R4 R5 R6 R8 R9 R10
    k = 0;
    for (int c = 0; c < 30; c++) begin
      exp_we = (k < NEXP) && (E_CYC[k] == c);
      chk(dbg_we == exp_we, $sformatf("R8 dbg_we cycle %0d", c), longint'(dbg_we), longint'(exp_we));
      if (exp_we) begin
        chk(dbg_idx == 4'(E_REG[k]), $sformatf("R2 R4 dbg_idx write %0d", k),
            longint'(dbg_idx), longint'(E_REG[k]));
        chk(dbg_data == XLEN'(E_VAL[k]), $sformatf("R2 R5 R9 dbg_data write %0d", k),
            longint'(dbg_data), E_VAL[k]);
        k++;
      end
      @(negedge clk);
    end
    chk(k == NEXP, "R6 write count", longint'(k), longint'(NEXP));

    // R7: reset mid-run keeps register file, restarts at PC 0
    rst = 1'b1;
    @(negedge clk);
    chk(dbg_we == 1'b0, "R7 dbg_we after reset", longint'(dbg_we), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 7; c++) begin
      exp_we = (c == 3) || (c == 6);
      chk(dbg_we == exp_we, $sformatf("R7 rerun dbg_we cycle %0d", c), longint'(dbg_we), longint'(exp_we));
      if (c == 3) chk(dbg_data == XLEN'(4900), "R7 rerun r9 from kept regs", longint'(dbg_data), 4900);
      if (c == 6) chk(dbg_data == XLEN'(7400), "R7 R4 rerun r8", longint'(dbg_data), 7400);
      @(negedge clk);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule